// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

This block holds two independent single-action timer channels that share a free-running time base supplied from outside. A channel set to capture latches the time base when the selected edge appears on its input pin. A channel set to compare drives its output flip-flop to a programmed level when the time base equals its stored value. Each channel has a sticky event flag, an interrupt enable and a force-output control. A shared interrupt level and an arbitration value, both held in channel A's control register, feed a combiner that gives channel A fixed priority over channel B. Each channel has its own vector.

A freeze input halts capture and compare events without losing any state. Registers stay accessible during freeze, and the force-output control still works. Software uses eight 16-bit locations: 0 is A control, 1 is A data, 2 is B control, 3 is B data, and 4 to 7 read as zero.

Each channel runs a four-state machine: IDLE (mode off), CAPTURE, COMPARE and HALTED. The transitions are as follows. From any running state, *freeze-enter* goes to HALTED while freeze is high. *Mode-follow* moves between IDLE, CAPTURE and COMPARE on the clock edge after a mode write. *Freeze-release* returns from HALTED to the state that the current mode selects. Events fire only in CAPTURE or COMPARE while freeze is low.

Top module: `cc_dual_timer`

## Requirements
- R1: In capture mode, the input pin is sampled by one flop. On the selected edge, which is rising for mode 01 and falling for mode 10, the data register takes the time base and the flag sets. The opposite edge has no effect.
- R2: In compare mode (mode 11), the first clock edge at which the time base equals the data register sets the output to the level bit (bit 5) and sets the flag (bit 0).
- R3: A compare match while the flag is already set still updates the output, and the flag stays set.
- R4: The flag clears only on a control write with bit 0 = 0, and only when that write follows a read of the same control register that returned the flag set. A write without that read, or a write with bit 0 = 1, leaves the flag set.
- R5: If an event and a valid clear occur at the same clock edge, the flag stays set.
- R6: The IN status bit (bit 2) returns the output flip-flop in compare mode and the sampled pin in the other modes.
- R7: irq_req_o is high exactly when some channel has flag and enable (bit 1) set and the 3-bit level (A control bits 10:8) is nonzero. irq_level_o and irq_arb_o output A's bits 10:8 and 15:12.
- R8: The vector output is VEC_BASE when channel A requests, and VEC_BASE+1 when only channel B requests. Channel A wins when both request.
- R9: While freeze is high, no capture, compare or flag set occurs. After freeze falls, events resume from the second clock edge. Pin edges that occurred during freeze are not recorded.
- R10: A control write with bit 6 = 1 and mode 11 drives the output to the written level bit on the next edge, including during freeze. The same write with any other mode leaves the output unchanged. Bit 6 reads as 0.
- R11: Control registers hold enable, mode and level at bits 1, 4:3 and 5. Channel B's bits 15:7 and both registers' bits 7 and 11 read as zero. Offsets 4 to 7 read as zero, and writes to them change nothing.
- R12: After reset, all registers read zero, both outputs are 0 and irq_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Halts capture and compare events |
| tbase_i | input | DW | Shared free-running time base |
| cap_pin_i | input | 2 | Input pins, bit 0 channel A, bit 1 channel B |
| cmp_out_o | output | 2 | Output flip-flops, bit 0 channel A, bit 1 channel B |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, combinational |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Shared interrupt level |
| irq_arb_o | output | 4 | Shared arbitration value |
| irq_vec_o | output | VW | Vector of the winning channel, 0 when idle |

## Verification
A wrong flag or arm state shows up at irq_req_o and irq_vec_o in the same cycle. It also shows up in the control read on the next access, for example as a flag that survives a proper clear or one that clears without a prior read. A channel state that lags or sticks in HALTED shows up as an output or captured value that is missing or late by one edge relative to the counted schedule. Because the bench samples exactly at the expected cycle, a single-cycle error is caught. Vector priority errors appear as soon as both flags are pending.

// File: rtl/ccdt_pkg.sv
package ccdt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_CAP_RISE = 2'b01,
        MODE_CAP_FALL = 2'b10,
        MODE_CMP      = 2'b11
    } ccdt_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_CAPTURE,
        CH_COMPARE,
        CH_HALTED
    } ccdt_state_e;

    typedef struct packed {
        ccdt_mode_e mode;
        logic       lvl;
        logic       ien;
    } ccdt_cfg_t;

    localparam int unsigned CTL_FLAG    = 0;
    localparam int unsigned CTL_IEN     = 1;
    localparam int unsigned CTL_IN      = 2;
    localparam int unsigned CTL_MODE_LO = 3;
    localparam int unsigned CTL_LVL     = 5;
    localparam int unsigned CTL_FORCE   = 6;
    localparam int unsigned CTL_ILVL_LO = 8;
    localparam int unsigned CTL_ARB_LO  = 12;

    function automatic ccdt_state_e run_state(input ccdt_mode_e m);
        ccdt_state_e s;
        unique case (m)
            MODE_OFF:                     s = CH_IDLE;
            MODE_CAP_RISE, MODE_CAP_FALL: s = CH_CAPTURE;
            MODE_CMP:                     s = CH_COMPARE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ccdt_channel.sv
module ccdt_channel
    import ccdt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze_i,
    input  logic [DW-1:0] tbase_i,
    input  logic          pin_i,
    input  logic          ctrl_we_i,
    input  logic          data_we_i,
    input  logic          stat_rd_i,
    input  logic [DW-1:0] wdata_i,
    output logic          flag_o,
    output logic          in_o,
    output logic          out_o,
    output logic [DW-1:0] data_o,
    output ccdt_cfg_t     cfg_o
);

    ccdt_state_e state_q, state_nx;
    ccdt_cfg_t   cfg_q;
    logic        flag_q, armed_q, out_q;
    logic [DW-1:0] data_q;
    logic        pin_s, pin_p;
    logic        rise, fall, cap_evt, cmp_evt, evt, clr, force_hit;
    ccdt_mode_e  wr_mode;

    // pin sampling and edge detection keep running during freeze
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_s <= 1'b0;
            pin_p <= 1'b0;
        end else begin
            pin_s <= pin_i;
            pin_p <= pin_s;
        end
    end

    assign rise = pin_s & ~pin_p;
    assign fall = ~pin_s & pin_p;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: freeze-enter, mode-follow, freeze-release
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CH_IDLE, CH_CAPTURE, CH_COMPARE: begin
                if (freeze_i) state_nx = CH_HALTED;
                else          state_nx = run_state(cfg_q.mode);
            end
            CH_HALTED: begin
                if (!freeze_i) state_nx = run_state(cfg_q.mode);
            end
        endcase
    end

    // event decode from state
    always_comb begin
        cap_evt = 1'b0;
        cmp_evt = 1'b0;
        unique case (state_q)
            CH_CAPTURE: cap_evt = !freeze_i &&
                        ((cfg_q.mode == MODE_CAP_RISE) ? rise : fall);
            CH_COMPARE: cmp_evt = !freeze_i && (tbase_i == data_q);
            CH_IDLE, CH_HALTED: ;
        endcase
    end

    assign evt       = cap_evt | cmp_evt;
    assign clr       = ctrl_we_i && armed_q && !wdata_i[CTL_FLAG];
    assign wr_mode   = ccdt_mode_e'(wdata_i[CTL_MODE_LO +: 2]);
    assign force_hit = ctrl_we_i && wdata_i[CTL_FORCE] && (wr_mode == MODE_CMP);

    // datapath and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            out_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (ctrl_we_i) begin
                cfg_q.mode <= wr_mode;
                cfg_q.lvl  <= wdata_i[CTL_LVL];
                cfg_q.ien  <= wdata_i[CTL_IEN];
            end
            if (evt)      flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (ctrl_we_i)                 armed_q <= 1'b0;
            else if (stat_rd_i && flag_q)  armed_q <= 1'b1;
            if (cap_evt)        data_q <= tbase_i;
            else if (data_we_i) data_q <= wdata_i;
            if (force_hit)    out_q <= wdata_i[CTL_LVL];
            else if (cmp_evt) out_q <= cfg_q.lvl;
        end
    end

    assign flag_o = flag_q;
    assign out_o  = out_q;
    assign data_o = data_q;
    assign cfg_o  = cfg_q;
    assign in_o   = (cfg_q.mode == MODE_CMP) ? out_q : pin_s;

endmodule

// File: rtl/ccdt_irq.sv
module ccdt_irq #(
    parameter int NCH      = 2,
    parameter int VW       = 8,
    parameter int VEC_BASE = 64
) (
    input  logic [NCH-1:0] flag_i,
    input  logic [NCH-1:0] ien_i,
    input  logic [2:0]     level_i,
    output logic           req_o,
    output logic [VW-1:0]  vec_o
);

    logic [NCH-1:0] pend;

    assign pend  = flag_i & ien_i & {NCH{|level_i}};
    assign req_o = |pend;

    // lowest index wins: scanned last
    always_comb begin
        vec_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) vec_o = VW'(VEC_BASE + i);
        end
    end

endmodule

// File: rtl/cc_dual_timer.sv
module cc_dual_timer
    import ccdt_pkg::*;
#(
    parameter int DW       = 16,
    parameter int VW       = 8,
    parameter int VEC_BASE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze_i,
    input  logic [DW-1:0] tbase_i,
    input  logic [1:0]    cap_pin_i,
    output logic [1:0]    cmp_out_o,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [2:0]    bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_req_o,
    output logic [2:0]    irq_level_o,
    output logic [3:0]    irq_arb_o,
    output logic [VW-1:0] irq_vec_o
);

    localparam int NCH = 2;

    logic [NCH-1:0]         flag_v, ien_v, in_v;
    logic [NCH-1:0][DW-1:0] data_v;
    ccdt_cfg_t              cfg_v [NCH];
    logic [NCH-1:0]         ctrl_we, data_we, stat_rd;
    logic [2:0]             ilvl_q;
    logic [3:0]             arb_q;
    logic                   in_block, rd_ch;

    assign in_block = bus_sel_i && !bus_addr_i[2];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ctrl_we[g] = in_block && bus_wr_i && (bus_addr_i[1] == 1'(g)) && !bus_addr_i[0];
        assign data_we[g] = in_block && bus_wr_i && (bus_addr_i[1] == 1'(g)) &&  bus_addr_i[0];
        assign stat_rd[g] = in_block && !bus_wr_i && (bus_addr_i[1] == 1'(g)) && !bus_addr_i[0];

        ccdt_channel #(.DW(DW)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .freeze_i  (freeze_i),
            .tbase_i   (tbase_i),
            .pin_i     (cap_pin_i[g]),
            .ctrl_we_i (ctrl_we[g]),
            .data_we_i (data_we[g]),
            .stat_rd_i (stat_rd[g]),
            .wdata_i   (bus_wdata_i),
            .flag_o    (flag_v[g]),
            .in_o      (in_v[g]),
            .out_o     (cmp_out_o[g]),
            .data_o    (data_v[g]),
            .cfg_o     (cfg_v[g])
        );
        assign ien_v[g] = cfg_v[g].ien;
    end

    // shared level and arbitration fields live in channel A's control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilvl_q <= '0;
            arb_q  <= '0;
        end else if (ctrl_we[0]) begin
            ilvl_q <= bus_wdata_i[CTL_ILVL_LO +: 3];
            arb_q  <= bus_wdata_i[CTL_ARB_LO +: 4];
        end
    end

    assign rd_ch = bus_addr_i[1];

    always_comb begin
        bus_rdata_o = '0;
        if (!bus_addr_i[2]) begin
            if (bus_addr_i[0]) begin
                bus_rdata_o = data_v[rd_ch];
            end else begin
                bus_rdata_o[CTL_FLAG]         = flag_v[rd_ch];
                bus_rdata_o[CTL_IEN]          = cfg_v[rd_ch].ien;
                bus_rdata_o[CTL_IN]           = in_v[rd_ch];
                bus_rdata_o[CTL_MODE_LO +: 2] = cfg_v[rd_ch].mode;
                bus_rdata_o[CTL_LVL]          = cfg_v[rd_ch].lvl;
                if (!rd_ch) begin
                    bus_rdata_o[CTL_ILVL_LO +: 3] = ilvl_q;
                    bus_rdata_o[CTL_ARB_LO +: 4]  = arb_q;
                end
            end
        end
    end

    ccdt_irq #(.NCH(NCH), .VW(VW), .VEC_BASE(VEC_BASE)) irq_i (
        .flag_i  (flag_v),
        .ien_i   (ien_v),
        .level_i (ilvl_q),
        .req_o   (irq_req_o),
        .vec_o   (irq_vec_o)
    );

    assign irq_level_o = ilvl_q;
    assign irq_arb_o   = arb_q;

endmodule

// File: rtl/ccdt_checker.sv
module ccdt_checker #(
    parameter int DW       = 16,
    parameter int VW       = 8,
    parameter int VEC_BASE = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               freeze_i,
    input logic               bus_sel_i,
    input logic               bus_wr_i,
    input logic [2:0]         bus_addr_i,
    input logic [DW-1:0]      bus_rdata_o,
    input logic [1:0]         cmp_out_o,
    input logic               irq_req_o,
    input logic [2:0]         irq_level_o,
    input logic [VW-1:0]      irq_vec_o,
    input logic [1:0]         flag_v,
    input logic [1:0]         ien_v,
    input logic [1:0][DW-1:0] data_v
);

    logic [1:0] cw, dw;
    for (genvar g = 0; g < 2; g++) begin : g_wr
        assign cw[g] = bus_sel_i && bus_wr_i && (bus_addr_i == 3'(2 * g));
        assign dw[g] = bus_sel_i && bus_wr_i && (bus_addr_i == 3'(2 * g + 1));

        a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_v[g] && !cw[g]) |=> flag_v[g]);

        a_r9_out_held: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze_i && !cw[g]) |=> $stable(cmp_out_o[g]));

        a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze_i && !dw[g]) |=> $stable(data_v[g]));
    end

    a_r7_level_needed: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_level_o != 3'd0));

    a_r7_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(flag_v & ien_v)) && (irq_level_o != 3'd0)) |-> irq_req_o);

    a_r8_a_first: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v[0] && ien_v[0] && (irq_level_o != 3'd0)) |-> (irq_vec_o == VW'(VEC_BASE)));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && bus_addr_i[2]) |-> (bus_rdata_o == '0));

endmodule

bind cc_dual_timer ccdt_checker #(.DW(DW), .VW(VW), .VEC_BASE(VEC_BASE)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze_i    (freeze_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .cmp_out_o   (cmp_out_o),
    .irq_req_o   (irq_req_o),
    .irq_level_o (irq_level_o),
    .irq_vec_o   (irq_vec_o),
    .flag_v      (flag_v),
    .ien_v       (ien_v),
    .data_v      (data_v)
);

// File: tb/cc_dual_timer_tb_top.sv
module cc_dual_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic [15:0] tbase = 16'h7777;
    logic [1:0]  pins = 2'b00;
    logic [1:0]  outs;
    logic        sel = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0, rdata;
    logic        req;
    logic [2:0]  lvl;
    logic [3:0]  arb;
    logic [7:0]  vec;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cc_dual_timer dut_i (
        .clk(clk), .rst_n(rst_n), .freeze_i(freeze), .tbase_i(tbase),
        .cap_pin_i(pins), .cmp_out_o(outs), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_req_o(req), .irq_level_o(lvl), .irq_arb_o(arb), .irq_vec_o(vec)
    );

    // {write, offset, wdata, expected read}
    localparam logic [35:0] TBL [16] = '{
        {1'b1, 3'd0, 16'hF5FF, 16'h0000},
        {1'b0, 3'd0, 16'h0000, 16'hF53E},
        {1'b1, 3'd1, 16'h1357, 16'h0000},
        {1'b0, 3'd1, 16'h0000, 16'h1357},
        {1'b1, 3'd2, 16'hFFFF, 16'h0000},
        {1'b0, 3'd2, 16'h0000, 16'h003E},
        {1'b1, 3'd3, 16'h2468, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h2468},
        {1'b1, 3'd5, 16'hFFFF, 16'h0000},
        {1'b0, 3'd5, 16'h0000, 16'h0000},
        {1'b0, 3'd4, 16'h0000, 16'h0000},
        {1'b0, 3'd6, 16'h0000, 16'h0000},
        {1'b0, 3'd7, 16'h0000, 16'h0000},
        {1'b0, 3'd0, 16'h0000, 16'hF53E},
        {1'b1, 3'd2, 16'h0000, 16'h0000},
        {1'b0, 3'd2, 16'h0000, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; freeze = 1'b0; pins = 2'b00; sel = 1'b0; wr = 1'b0;
        tbase = 16'h7777;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rreg(a, d);
        chk(tag, 32'(d), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R12 reset state
        do_reset();
        @(negedge clk);
        chk("R12 outputs", {outs, req}, 3'b000);
        for (int a = 0; a < 8; a++) rchk("R12 register", 3'(a), 16'h0000);

        // R11 register map table (also R6, R10 via force in compare mode)
        for (int i = 0; i < 16; i++) begin
            if (TBL[i][35]) wreg(TBL[i][34:32], TBL[i][31:16]);
            else            rchk("R11 table", TBL[i][34:32], TBL[i][15:0]);
        end
        chk("R10 table force outputs", outs, 2'b11);

        // R1 capture, R4 clear, R7 request, R8 priority
        do_reset();
        tbase = 16'h1111;
        wreg(3'd0, 16'h030A);
        repeat (2) @(negedge clk);
        pins[0] = 1'b1;
        repeat (3) @(negedge clk);
        rchk("R1 rise capture data", 3'd1, 16'h1111);
        rchk("R1 rise flag", 3'd0, 16'h030F);
        chk("R7 req", {req, lvl}, {1'b1, 3'd3});
        chk("R8 vector A", vec, 8'h40);
        wreg(3'd2, 16'h0010);
        repeat (2) @(negedge clk);
        pins[1] = 1'b1;
        repeat (3) @(negedge clk);
        rchk("R1 rise ignored in fall mode", 3'd2, 16'h0014);
        tbase = 16'h2222;
        pins[1] = 1'b0;
        repeat (3) @(negedge clk);
        rchk("R1 fall capture data", 3'd3, 16'h2222);
        rchk("R1 fall flag", 3'd2, 16'h0011);
        wreg(3'd2, 16'h0013);
        @(negedge clk);
        chk("R8 A wins over B", vec, 8'h40);
        wreg(3'd0, 16'h000B);
        @(negedge clk);
        chk("R7 level zero masks", req, 1'b0);
        wreg(3'd0, 16'h030B);
        rchk("R4 A still set", 3'd0, 16'h030F);
        wreg(3'd0, 16'h030A);
        @(negedge clk);
        chk("R8 vector B", {req, vec}, {1'b1, 8'h41});
        wreg(3'd2, 16'h0012);
        rchk("R4 write without read keeps flag", 3'd2, 16'h0013);
        wreg(3'd2, 16'h0013);
        rchk("R4 write of one keeps flag", 3'd2, 16'h0013);
        wreg(3'd2, 16'h0012);
        rchk("R4 proper clear", 3'd2, 16'h0012);
        chk("R7 no request", req, 1'b0);

        // R2 compare, R3 sticky, R6 IN, R10 force
        do_reset();
        tbase = 16'h0100;
        wreg(3'd1, 16'h0200);
        wreg(3'd0, 16'h003A);
        repeat (2) @(negedge clk);
        chk("R2 before match", outs[0], 1'b0);
        tbase = 16'h0200;
        @(negedge clk);
        chk("R2 match drives level", outs[0], 1'b1);
        tbase = 16'h0300;
        rchk("R6 IN shows output", 3'd0, 16'h003F);
        wreg(3'd0, 16'h001B);
        @(negedge clk);
        tbase = 16'h0200;
        @(negedge clk);
        chk("R3 match with flag set", outs[0], 1'b0);
        tbase = 16'h0300;
        rchk("R3 flag stays", 3'd0, 16'h001B);
        wreg(3'd0, 16'h007B);
        chk("R10 force in compare", outs[0], 1'b1);
        wreg(3'd2, 16'h0068);
        chk("R10 force ignored in capture", outs[1], 1'b0);

        // R9 freeze
        wreg(3'd0, 16'h001B);
        @(negedge clk);
        freeze = 1'b1;
        tbase = 16'h0200;
        repeat (3) @(negedge clk);
        chk("R9 compare held", outs[0], 1'b1);
        pins[1] = 1'b1;
        repeat (3) @(negedge clk);
        rchk("R9 no capture, R6 IN in freeze", 3'd2, 16'h002C);
        wreg(3'd0, 16'h005B);
        chk("R10 force during freeze", outs[0], 1'b0);
        wreg(3'd0, 16'h003B);
        repeat (2) @(negedge clk);
        chk("R9 still held", outs[0], 1'b0);
        freeze = 1'b0;
        @(negedge clk);
        chk("R9 first edge after release", outs[0], 1'b0);
        @(negedge clk);
        chk("R9 resume", outs[0], 1'b1);
        rchk("R9 lost edge", 3'd2, 16'h002C);
        rchk("R9 B data untouched", 3'd3, 16'h0000);

        // R5 set beats clear
        do_reset();
        tbase = 16'h0010;
        wreg(3'd1, 16'h0050);
        wreg(3'd0, 16'h0038);
        repeat (2) @(negedge clk);
        tbase = 16'h0050;
        @(negedge clk);
        tbase = 16'h0010;
        rchk("R5 flag set", 3'd0, 16'h003D);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 3'd0; wdata = 16'h0038; tbase = 16'h0050;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tbase = 16'h0010;
        rchk("R5 set wins", 3'd0, 16'h003D);
        wreg(3'd0, 16'h0038);
        rchk("R5 later clear", 3'd0, 16'h003C);

        finish_run();
    end

endmodule